// File: doc/BRIEF.md
# Indexed Plug-and-Play Configuration Register File

This block is the configuration space of a multi-function peripheral, reached through two adjacent byte ports in I/O space. A write to the first port (the index port) picks one of 256 register offsets. Reads and writes of the second port (the data port) then act on the register at that offset. Nothing can be changed until a key is written to the index port, and a closing key shuts access again. While access is shut, both ports read as all ones.

The offsets from 0x00 to 0x2F are common to all functions. Offset 0x07 picks which of the logical devices the banked offsets 0x30 to 0xFF refer to. Each logical device holds an 8-bit enable register, a 16-bit I/O base, two interrupt selections and two DMA channel selections. Its I/O base bits are forced to zero wherever that device's mask parameter is zero. This fixes both the size of the resource and the highest base it can take. All per-device settings are driven out continuously for the functional units.

The key logic is a state machine with three states. `ST_LOCKED` moves to `ST_KEY_ONE` on an index write of 0x87. `ST_KEY_ONE` moves to `ST_OPEN` on a second 0x87 and falls back to `ST_LOCKED` on any other index write. `ST_OPEN` returns to `ST_LOCKED` on an index write of 0xAA. Data-port writes never change the state.

Top module: `pnp_cfg_regfile`

## Requirements
- R1: While unlocked, an index-port write loads the 8-bit index, an index-port read returns it, and data-port accesses act on the register at that index. Outside a read strobe, and for addresses outside the two ports, the read data is 0x00.
- R2: While not unlocked (states ST_LOCKED and ST_KEY_ONE), reads of either port return 0xFF, data-port writes change no register, and index-port writes do not load the index.
- R3: Access opens only after two index-port writes of 0x87 in a row. Any other index-port write between them cancels the first key.
- R4: While unlocked, an index-port write of 0xAA locks the block and leaves the index unchanged.
- R5: Offset 0x07 holds the logical device number in its low 2 bits, and its upper bits read 0. Every other offset from 0x00 to 0x2F reads 0x00 and ignores writes, whatever device is selected.
- R6: Offsets 0x30 to 0xFF act only on the logical device selected through offset 0x07. A write there leaves the other devices unchanged.
- R7: Offset 0x30 is an 8-bit enable register per device, driven on dev_enable[8*d+7:8*d].
- R8: Offsets 0x60 (high byte) and 0x61 (low byte) form a 16-bit I/O base per device. Bits where the device's mask is 0 are stored as 0, so writing 0xFF to both reads back the mask. The default masks are 0x07F8, 0x0FFC, 0x03F0 and 0x0FF8 for devices 0 to 3.
- R9: Offsets 0x70 and 0x72 hold interrupt numbers in bits 3:0, and their upper bits read 0. They drive dev_irq_num (bits 3:0 for the first, bits 7:4 for the second). The matching dev_irq_en bit is 1 exactly when the number is nonzero.
- R10: Offsets 0x71 and 0x73 store only bit 1, the polarity, which drives dev_irq_pol. Bit 0, the type, always reads 0 (edge), and the other bits read 0.
- R11: Offsets 0x74 and 0x75 hold 3-bit DMA channel numbers in bits 2:0, driven on dev_dma (bits 2:0 and 5:3). Their upper bits read 0.
- R12: Banked offsets other than 0x30, 0x60, 0x61 and 0x70 to 0x75 read 0x00 and ignore writes. After reset the block is locked, and the index, the device number and every register are 0, except the DMA registers, which are 4 (no channel).
- R13: When a data-port read and a data-port write fall in the same cycle, the read returns the value held before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while io_rd is high |
| dev_enable | output | 8*NUM_DEV | Enable register of each device |
| dev_io_base | output | 16*NUM_DEV | Masked I/O base of each device |
| dev_irq_num | output | 8*NUM_DEV | Two 4-bit interrupt numbers per device |
| dev_irq_en | output | 2*NUM_DEV | Interrupt enable, number nonzero |
| dev_irq_pol | output | 2*NUM_DEV | Interrupt polarity bits |
| dev_dma | output | 6*NUM_DEV | Two 3-bit DMA channels per device |

## Verification
A data-port read and a data-port write can be presented in the same cycle, and the read then races the register update. The bench raises both strobes together on the enable register. It samples the read data before the clock edge and expects the old value. After the edge it reads the register again and expects the written value. A second coincidence is the closing key written while an index is held: the bench checks that locking happens and that the index survives the lock and the next unlock.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_KEY_ONE = 2'd1,
        ST_OPEN    = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_OPEN      = 8'h87;
    localparam logic [7:0] KEY_CLOSE     = 8'hAA;
    localparam logic [7:0] REG_LDN       = 8'h07;
    localparam logic [7:0] BANK_START    = 8'h30;
    localparam logic [7:0] REG_ENABLE    = 8'h30;
    localparam logic [7:0] REG_BASE_HI   = 8'h60;
    localparam logic [7:0] REG_BASE_LO   = 8'h61;
    localparam logic [7:0] REG_IRQ0      = 8'h70;
    localparam logic [7:0] REG_IRQ0_TYPE = 8'h71;
    localparam logic [7:0] REG_IRQ1      = 8'h72;
    localparam logic [7:0] REG_IRQ1_TYPE = 8'h73;
    localparam logic [7:0] REG_DMA0      = 8'h74;
    localparam logic [7:0] REG_DMA1      = 8'h75;
    localparam logic [2:0] DMA_NONE      = 3'd4;

endpackage

// File: rtl/pnp_key_fsm.sv
module pnp_key_fsm
    import pnp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       idx_load
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        idx_load = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_OPEN) state_d = ST_KEY_ONE;
            end
            ST_KEY_ONE: begin
                if (idx_wr) state_d = (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
            end
            ST_OPEN: begin
                if (idx_wr) begin
                    if (wdata == KEY_CLOSE) state_d  = ST_LOCKED;
                    else                    idx_load = 1'b1;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    assign unlocked = (state_q == ST_OPEN);

endmodule

// File: rtl/pnp_ldn_bank.sv
module pnp_ldn_bank
    import pnp_cfg_pkg::*;
#(
    parameter logic [15:0] IO_MASK = 16'h07F8
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  enable,
    output logic [15:0] io_base,
    output logic [7:0]  irq_num,
    output logic [1:0]  irq_pol,
    output logic [5:0]  dma
);

    logic [7:0]  enable_q;
    logic [15:0] base_q;
    logic [3:0]  irq0_q, irq1_q;
    logic        pol0_q, pol1_q;
    logic [2:0]  dma0_q, dma1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            base_q   <= '0;
            irq0_q   <= '0;
            irq1_q   <= '0;
            pol0_q   <= 1'b0;
            pol1_q   <= 1'b0;
            dma0_q   <= DMA_NONE;
            dma1_q   <= DMA_NONE;
        end else if (we) begin
            case (idx)
                REG_ENABLE:    enable_q     <= wdata;
                REG_BASE_HI:   base_q[15:8] <= wdata & IO_MASK[15:8];
                REG_BASE_LO:   base_q[7:0]  <= wdata & IO_MASK[7:0];
                REG_IRQ0:      irq0_q       <= wdata[3:0];
                REG_IRQ0_TYPE: pol0_q       <= wdata[1];
                REG_IRQ1:      irq1_q       <= wdata[3:0];
                REG_IRQ1_TYPE: pol1_q       <= wdata[1];
                REG_DMA0:      dma0_q       <= wdata[2:0];
                REG_DMA1:      dma1_q       <= wdata[2:0];
                default:       ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            REG_ENABLE:    rdata = enable_q;
            REG_BASE_HI:   rdata = base_q[15:8];
            REG_BASE_LO:   rdata = base_q[7:0];
            REG_IRQ0:      rdata = {4'h0, irq0_q};
            REG_IRQ0_TYPE: rdata = {6'h0, pol0_q, 1'b0};
            REG_IRQ1:      rdata = {4'h0, irq1_q};
            REG_IRQ1_TYPE: rdata = {6'h0, pol1_q, 1'b0};
            REG_DMA0:      rdata = {5'h0, dma0_q};
            REG_DMA1:      rdata = {5'h0, dma1_q};
            default:       rdata = 8'h00;
        endcase
    end

    assign enable  = enable_q;
    assign io_base = base_q;
    assign irq_num = {irq1_q, irq0_q};
    assign irq_pol = {pol1_q, pol0_q};
    assign dma     = {dma1_q, dma0_q};

endmodule

// File: rtl/pnp_cfg_regfile.sv
module pnp_cfg_regfile
    import pnp_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h002E,
    parameter int          NUM_DEV   = 4,
    parameter logic [16*NUM_DEV-1:0] IO_MASKS =
        {16'h0FF8, 16'h03F0, 16'h0FFC, 16'h07F8}
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic [8*NUM_DEV-1:0]   dev_enable,
    output logic [16*NUM_DEV-1:0]  dev_io_base,
    output logic [8*NUM_DEV-1:0]   dev_irq_num,
    output logic [2*NUM_DEV-1:0]   dev_irq_en,
    output logic [2*NUM_DEV-1:0]   dev_irq_pol,
    output logic [6*NUM_DEV-1:0]   dev_dma
);

    localparam int          LDN_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

    logic             hit_idx, hit_dat;
    logic             unlocked, idx_load;
    logic [7:0]       cfg_index;
    logic [LDN_W-1:0] ldn_q;
    logic             data_we;
    logic [7:0]       bank_rdata [NUM_DEV];
    logic [7:0]       sel_rdata, data_val;

    assign hit_idx = (io_addr == BASE_ADDR);
    assign hit_dat = (io_addr == DATA_ADDR);

    pnp_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && hit_idx),
        .wdata    (io_wdata),
        .unlocked (unlocked),
        .idx_load (idx_load)
    );

    assign data_we = io_wr && hit_dat && unlocked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_index <= '0;
            ldn_q     <= '0;
        end else begin
            if (idx_load) cfg_index <= io_wdata;
            if (data_we && cfg_index == REG_LDN) ldn_q <= io_wdata[LDN_W-1:0];
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [7:0] irq_n;
        pnp_ldn_bank #(
            .IO_MASK (IO_MASKS[16*d +: 16])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (data_we && cfg_index >= BANK_START && ldn_q == LDN_W'(d)),
            .idx     (cfg_index),
            .wdata   (io_wdata),
            .rdata   (bank_rdata[d]),
            .enable  (dev_enable[8*d +: 8]),
            .io_base (dev_io_base[16*d +: 16]),
            .irq_num (irq_n),
            .irq_pol (dev_irq_pol[2*d +: 2]),
            .dma     (dev_dma[6*d +: 6])
        );
        assign dev_irq_num[8*d +: 8] = irq_n;
        assign dev_irq_en[2*d]       = (irq_n[3:0] != 4'h0);
        assign dev_irq_en[2*d+1]     = (irq_n[7:4] != 4'h0);
    end

    always_comb begin
        sel_rdata = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (ldn_q == LDN_W'(d)) sel_rdata = bank_rdata[d];
        end
    end

    always_comb begin
        if (cfg_index >= BANK_START)  data_val = sel_rdata;
        else if (cfg_index == REG_LDN) data_val = {{(8-LDN_W){1'b0}}, ldn_q};
        else                           data_val = 8'h00;
    end

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd && hit_idx)      io_rdata = unlocked ? cfg_index : 8'hFF;
        else if (io_rd && hit_dat) io_rdata = unlocked ? data_val  : 8'hFF;
    end

endmodule

// File: rtl/pnp_cfg_checker.sv
module pnp_cfg_checker #(
    parameter logic [15:0] BASE_ADDR = 16'h002E,
    parameter int          NUM_DEV   = 4,
    parameter logic [16*NUM_DEV-1:0] IO_MASKS = '0
)(
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic                  unlocked,
    input logic [7:0]            cfg_index,
    input logic [8*NUM_DEV-1:0]  dev_enable,
    input logic [16*NUM_DEV-1:0] dev_io_base
);

    localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

    // R2: closed block answers all ones on the data port
    a_r2_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd && io_addr == DATA_ADDR) |-> io_rdata == 8'hFF);

    // R2: data writes while closed change no enable or base
    a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_wr && io_addr == DATA_ADDR)
        |=> ($stable(dev_enable) && $stable(dev_io_base)));

    // R3: opening is always preceded by an index write of the key
    a_r3_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == 8'h87));

    // R4: closing key locks and keeps the index
    a_r4_close_key: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_wr && io_addr == BASE_ADDR && io_wdata == 8'hAA)
        |=> (!unlocked && $stable(cfg_index)));

    // R10: type bit reads edge, other bits zero
    a_r10_type_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_rd && io_addr == DATA_ADDR &&
         (cfg_index == 8'h71 || cfg_index == 8'h73))
        |-> (io_rdata[0] == 1'b0 && io_rdata[7:2] == 6'h00));

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_mask
        // R8: base never holds a bit outside the mask
        a_r8_base_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_io_base[16*d +: 16] & ~IO_MASKS[16*d +: 16]) == 16'h0000);
    end

endmodule

bind pnp_cfg_regfile pnp_cfg_checker #(
    .BASE_ADDR (BASE_ADDR),
    .NUM_DEV   (NUM_DEV),
    .IO_MASKS  (IO_MASKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .unlocked    (unlocked),
    .cfg_index   (cfg_index),
    .dev_enable  (dev_enable),
    .dev_io_base (dev_io_base)
);

// File: tb/test_pnp_cfg_regfile.sv
`timescale 1ns/1ps
module test_pnp_cfg_regfile;

    localparam int          NDEV = 4;
    localparam logic [15:0] IDX  = 16'h002E;
    localparam logic [15:0] DAT  = 16'h002F;
    localparam logic [15:0] MASKS [NDEV] = '{16'h07F8, 16'h0FFC, 16'h03F0, 16'h0FF8};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [8*NDEV-1:0]  dev_enable;
    logic [16*NDEV-1:0] dev_io_base;
    logic [8*NDEV-1:0]  dev_irq_num;
    logic [2*NDEV-1:0]  dev_irq_en;
    logic [2*NDEV-1:0]  dev_irq_pol;
    logic [6*NDEV-1:0]  dev_dma;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pnp_cfg_regfile i_pnp_cfg_regfile (
        .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
        .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
        .dev_enable (dev_enable), .dev_io_base (dev_io_base),
        .dev_irq_num (dev_irq_num), .dev_irq_en (dev_irq_en),
        .dev_irq_pol (dev_irq_pol), .dev_dma (dev_dma)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
        io_write(IDX, i);
        io_write(DAT, d);
    endtask

    task automatic cfg_rd(input logic [7:0] i, output logic [7:0] d);
        io_write(IDX, i);
        io_read(DAT, d);
    endtask

    task automatic open_key();
        io_write(IDX, 8'h87);
        io_write(IDX, 8'h87);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        io_read(DAT, r);
        check("R12/R2 reset data port locked", r, 8'hFF);
        io_read(IDX, r);
        check("R2 reset index port locked", r, 8'hFF);
        check("R12 reset enables", dev_enable, '0);
        check("R12 reset bases", dev_io_base, '0);
        check("R12 reset dma none", dev_dma, {NDEV{6'o44}});
        io_read(16'h0030, r);
        check("R1 other address reads zero", r, 8'h00);
    endtask

    task automatic t_key();
        logic [7:0] r;
        io_write(IDX, 8'h87);
        io_write(IDX, 8'h12);
        io_write(IDX, 8'h87);
        io_read(DAT, r);
        check("R3 broken key stays closed", r, 8'hFF);
        io_write(IDX, 8'h00);
        open_key();
        io_read(IDX, r);
        check("R3 key keeps reset index", r, 8'h00);
        io_write(IDX, 8'h07);
        io_read(IDX, r);
        check("R1 index port reads index", r, 8'h07);
        io_read(DAT, r);
        check("R12 ldn reset", r, 8'h00);
    endtask

    task automatic t_locked_write();
        logic [7:0] r;
        cfg_wr(8'h07, 8'h00);
        io_write(IDX, 8'h30);
        io_write(IDX, 8'hAA);
        io_write(DAT, 8'hFF);
        io_write(IDX, 8'h45);
        check("R2 locked write ignored", dev_enable[7:0], 8'h00);
        open_key();
        io_read(IDX, r);
        check("R2 locked index write ignored", r, 8'h30);
    endtask

    task automatic t_shared();
        logic [7:0] r;
        cfg_wr(8'h07, 8'h02);
        cfg_rd(8'h07, r);
        check("R5 ldn readback", r, 8'h02);
        cfg_wr(8'h07, 8'hFD);
        cfg_rd(8'h07, r);
        check("R5 ldn low bits only", r, 8'h01);
        cfg_wr(8'h2A, 8'h5A);
        cfg_rd(8'h2A, r);
        check("R5 shared unimplemented", r, 8'h00);
    endtask

    task automatic t_banks();
        logic [7:0] r;
        for (int d = 0; d < NDEV; d++) begin
            cfg_wr(8'h07, 8'(d));
            cfg_wr(8'h30, 8'(8'h10 + d));
        end
        for (int d = 0; d < NDEV; d++) begin
            check("R6/R7 enable output per device", dev_enable[8*d +: 8], 8'(8'h10 + d));
            cfg_wr(8'h07, 8'(d));
            cfg_rd(8'h30, r);
            check("R6 enable readback per device", r, 8'(8'h10 + d));
        end
    endtask

    task automatic t_mask();
        logic [7:0] hi, lo;
        for (int d = 0; d < NDEV; d++) begin
            cfg_wr(8'h07, 8'(d));
            cfg_wr(8'h60, 8'hFF);
            cfg_wr(8'h61, 8'hFF);
            cfg_rd(8'h60, hi);
            cfg_rd(8'h61, lo);
            check("R8 all ones reads mask", {hi, lo}, MASKS[d]);
            check("R8 base output", dev_io_base[16*d +: 16], MASKS[d]);
        end
        cfg_wr(8'h07, 8'h00);
        cfg_wr(8'h60, 8'h12);
        cfg_wr(8'h61, 8'h34);
        check("R8 masked pattern", dev_io_base[15:0], 16'h0230);
        check("R6 other base untouched", dev_io_base[31:16], MASKS[1]);
    endtask

    task automatic t_irq_dma();
        logic [7:0] r;
        cfg_wr(8'h07, 8'h01);
        cfg_wr(8'h70, 8'hF5);
        cfg_rd(8'h70, r);
        check("R9 irq number readback", r, 8'h05);
        check("R9 irq number output", dev_irq_num[11:8], 4'h5);
        check("R9 irq enable on", dev_irq_en[3:2], 2'b01);
        cfg_wr(8'h72, 8'h0C);
        check("R9 second irq", {dev_irq_num[15:12], dev_irq_en[3]}, {4'hC, 1'b1});
        cfg_wr(8'h70, 8'h00);
        check("R9 irq disabled by zero", dev_irq_en[2], 1'b0);
        cfg_wr(8'h71, 8'hFF);
        cfg_rd(8'h71, r);
        check("R10 type edge polarity kept", r, 8'h02);
        check("R10 polarity output", dev_irq_pol[3:2], 2'b01);
        cfg_wr(8'h74, 8'hFE);
        cfg_rd(8'h74, r);
        check("R11 dma readback", r, 8'h06);
        cfg_rd(8'h75, r);
        check("R11 dma reset none", r, 8'h04);
        check("R11 dma output", dev_dma[11:6], 6'o46);
        cfg_wr(8'h40, 8'hFF);
        cfg_rd(8'h40, r);
        check("R12 banked unimplemented", r, 8'h00);
        cfg_wr(8'h31, 8'hFF);
        cfg_rd(8'h31, r);
        check("R12 offset 0x31 unimplemented", r, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] r;
        cfg_wr(8'h07, 8'h00);
        io_write(IDX, 8'h30);
        @(negedge clk);
        io_addr = DAT; io_wdata = 8'hA5; io_wr = 1'b1; io_rd = 1'b1;
        #1 r = io_rdata;
        check("R13 read sees old value", r, 8'h10);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        io_read(DAT, r);
        check("R13 write still lands", r, 8'hA5);
    endtask

    task automatic t_lock();
        logic [7:0] r;
        io_write(IDX, 8'h60);
        io_write(IDX, 8'hAA);
        io_read(IDX, r);
        check("R4 locked index port", r, 8'hFF);
        io_read(DAT, r);
        check("R4 locked data port", r, 8'hFF);
        open_key();
        io_read(IDX, r);
        check("R4 index kept across lock", r, 8'h60);
        io_read(DAT, r);
        check("R1 data at kept index", r, 8'h02);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_key();
        t_locked_write();
        t_shared();
        t_banks();
        t_mask();
        t_irq_dma();
        t_same_cycle();
        t_lock();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule